// File: doc/BRIEF.md
# Daisy-Chainable Serial Receive Front End

This block receives a three-wire serial stream (serial clock, active-low chip select, data in) and does all its work in the system clock domain. The serial pins are brought into that domain through synchronizer flops, and their edges are detected there. While the select is low, each rising serial-clock edge shifts the data bit into a 16-bit register, most significant bit first. When the select rises, the register contents are handed to the downstream command logic as one parallel word with a single-cycle strobe.

The register's top bit is launched onto a serial data output, so several devices can be chained output-to-input. A mode input chooses the launch edge. With a falling-edge launch, the output trails the input by 16 serial clocks. With a rising-edge launch, it trails by 15.5 serial clocks. A hold input freezes the output, for example while the device is shut down. If a frame carries more than 16 clocks, the word delivered is the last 16 bits received, so extra bits pass on down the chain. The system clock must run at least four times faster than the serial clock.

Top module: `daisy_shift_port`

## Requirements
- R1: During and just after reset, `dout` is 0, `word_q` is 0 and `word_stb` is 0.
- R2: For each rising `sclk` edge seen while `cs_n` is low, the `din` level is shifted into the low end of a 16-bit register, and the older bits move toward bit 15. The first bit sent ends up as the most significant bit.
- R3: `sclk` edges that occur while `cs_n` is high change neither the shift register nor `dout`.
- R4: On each rising edge of `cs_n`, `word_stb` is high for exactly one system clock, and `word_q` holds the shift register contents.
- R5: A frame longer than 16 clocks delivers its last 16 bits. A frame shorter than 16 clocks delivers its new bits in the low end, with bits left over from earlier frames above them.
- R6: With `mode_rise` = 0, `dout` changes only on a falling `sclk` edge while `cs_n` is low. It then takes the register's bit 15, which gives a 16-clock lag from `din`.
- R7: With `mode_rise` = 1, `dout` changes only on a rising `sclk` edge while `cs_n` is low. It then takes the bit that becomes bit 15 through that shift, which gives a 15.5-clock lag.
- R8: While `hold` is 1, `dout` keeps its value. Shifting continues.
- R9: `word_q` changes only in a cycle in which `word_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| din | input | 1 | Serial data in (asynchronous) |
| mode_rise | input | 1 | 0: launch `dout` on falling `sclk`; 1: launch on rising `sclk` |
| hold | input | 1 | Freeze `dout` |
| dout | output | 1 | Serial data out toward the next device in the chain |
| word_q | output | 16 | Last received word |
| word_stb | output | 1 | One-cycle pulse: `word_q` is new |

## Verification
The assertions check four rules on every system clock:
- the strobe never lasts longer than one cycle;
- the delivered word never moves without the strobe;
- the output stays still under hold, and away from the launch edge chosen by the mode;
- the shift register stays still while the select is high.

The actual bit values need the bench's scenarios. These cover MSB-first ordering, the last-16-bits rule for long and short frames, the exact lag of the output in each mode, and the way bits left over after an ignored idle burst carry into the next word.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic {
    LAUNCH_FALL = 1'b0,
    LAUNCH_RISE = 1'b1
  } launch_e;

  localparam int PIN_SCLK = 2;
  localparam int PIN_CSN  = 1;
  localparam int PIN_DIN  = 0;
  localparam int PIN_CNT  = 3;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_n = d;
    end else begin : g_many
      always_comb stg_n = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dsp_edge.sv
module dsp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic csn_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise
);
  logic sclk_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_rise   = csn_s & ~csn_d;
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter
  import dsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              fall_en,
  input  logic              bit_in,
  input  launch_e           mode,
  input  logic              hold,
  output logic [WORD_W-1:0] sh_q,
  output logic              dout
);
  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] sh_n;
  logic              dout_n;

  always_comb begin
    sh_n = sh_q;
    if (shift_en) sh_n = {sh_q[TOP-1:0], bit_in};
  end

  always_comb begin
    dout_n = dout;
    if (!hold) begin
      if (mode == LAUNCH_RISE && shift_en)     dout_n = sh_q[TOP-1];
      else if (mode == LAUNCH_FALL && fall_en) dout_n = sh_q[TOP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      dout <= 1'b0;
    end else begin
      sh_q <= sh_n;
      dout <= dout_n;
    end
  end
endmodule

// File: rtl/dsp_frame.sv
module dsp_frame #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [WORD_W-1:0] sh_q,
  output logic [WORD_W-1:0] word_q,
  output logic              word_stb
);
  logic [WORD_W-1:0] word_n;

  always_comb begin
    word_n = word_q;
    if (cs_rise) word_n = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_stb <= 1'b0;
    end else begin
      word_q   <= word_n;
      word_stb <= cs_rise;
    end
  end
endmodule

// File: rtl/daisy_shift_port.sv
module daisy_shift_port
  import dsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              mode_rise,
  input  logic              hold,
  output logic              dout,
  output logic [WORD_W-1:0] word_q,
  output logic              word_stb
);
  localparam logic [PIN_CNT-1:0] PIN_RST = (1 << PIN_CSN);

  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic               sclk_rise, sclk_fall, cs_rise;
  logic               cs_s, din_s, shift_en, fall_en;
  logic [WORD_W-1:0]  sh_q;
  launch_e            mode;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk;
    pins_raw[PIN_CSN]  = cs_n;
    pins_raw[PIN_DIN]  = din;
  end

  dsp_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  assign cs_s  = pins_s[PIN_CSN];
  assign din_s = pins_s[PIN_DIN];

  dsp_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[PIN_SCLK]), .csn_s(cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise)
  );

  assign shift_en = sclk_rise & ~cs_s;
  assign fall_en  = sclk_fall & ~cs_s;
  assign mode     = launch_e'(mode_rise);

  dsp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .fall_en(fall_en),
    .bit_in(din_s), .mode(mode), .hold(hold), .sh_q(sh_q), .dout(dout)
  );

  dsp_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .sh_q(sh_q),
    .word_q(word_q), .word_stb(word_stb)
  );
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_rise,
  input logic              hold,
  input logic              cs_s,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic [WORD_W-1:0] sh_q,
  input logic              dout,
  input logic [WORD_W-1:0] word_q,
  input logic              word_stb
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb); // R4

  AST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> $stable(word_q)); // R9

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(dout)); // R8

  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> $stable(sh_q)); // R3

  AST_FALL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mode_rise && !(sclk_fall && !cs_s)) |-> $stable(dout)); // R6

  AST_RISE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_rise && !(sclk_rise && !cs_s)) |-> $stable(dout)); // R7

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_OUT: assert (dout == 1'b0 && word_stb == 1'b0); // R1
    end
  end
endmodule

bind daisy_shift_port dsp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rise(mode_rise), .hold(hold),
  .cs_s(cs_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .sh_q(sh_q), .dout(dout), .word_q(word_q), .word_stb(word_stb)
);

// File: tb/sim_daisy_shift_port.sv
module sim_daisy_shift_port;
  logic        clk, rst_n, sclk, cs_n, din, mode_rise, hold;
  logic        dout, word_stb;
  logic [15:0] word_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_sh;
  logic        m_dout;

  daisy_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .mode_rise(mode_rise), .hold(hold), .dout(dout),
    .word_q(word_q), .word_stb(word_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] shift_in(input logic [15:0] s, input logic b);
    return {s[14:0], b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: bits sent MSB first from bits[n-1]
  task automatic run_frame(input int n, input logic [63:0] bits, input logic hold_v);
    int stb_cnt;
    hold = hold_v;
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      din = bits[n-1-i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      m_sh = shift_in(m_sh, bits[n-1-i]);
      if (mode_rise && !hold_v) m_dout = m_sh[15];
      check(mode_rise ? "R7 dout after rise" : "R6 dout after rise", dout, m_dout);
      sclk = 1'b0;
      wait_clk(4);
      if (!mode_rise && !hold_v) m_dout = m_sh[15];
      check(hold_v ? "R8 dout held" : (mode_rise ? "R7 dout after fall" : "R6 dout after fall"),
            dout, m_dout);
    end
    cs_n = 1'b1;
    stb_cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (word_stb) stb_cnt++;
    end
    check("R4 strobe count", stb_cnt, 1);
    check(n > 16 ? "R5 last 16 bits" : "R2 word value", word_q, m_sh);
    hold = 1'b0;
    wait_clk(2);
  endtask

  task automatic idle_toggles(input int n);
    int stb_cnt;
    logic [15:0] w0;
    w0 = word_q;
    stb_cnt = 0;
    for (int i = 0; i < n; i++) begin
      din = 1'($urandom);
      for (int k = 0; k < 4; k++) begin @(negedge clk); if (word_stb) stb_cnt++; end
      sclk = 1'b1;
      for (int k = 0; k < 4; k++) begin @(negedge clk); if (word_stb) stb_cnt++; end
      check("R3 dout idle", dout, m_dout);
      sclk = 1'b0;
    end
    wait_clk(4);
    check("R3 dout idle end", dout, m_dout);
    check("R9 no strobe idle", stb_cnt, 0);
    check("R9 word unchanged", word_q, w0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    mode_rise = 1'b0; hold = 1'b0;
    m_sh = '0; m_dout = 1'b0;
    wait_clk(3);
    check("R1 reset dout", dout, 0);
    check("R1 reset word", word_q, 0);
    check("R1 reset strobe", word_stb, 0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 after release dout", dout, 0);
    check("R1 after release word", word_q, 0);

    // directed: MSB-first ordering, fall launch
    run_frame(16, 64'hA5C3, 1'b0);
    run_frame(16, 64'h0001, 1'b0);
    // rise launch, all ones then alternating
    mode_rise = 1'b1;
    run_frame(16, 64'hFFFF, 1'b0);
    run_frame(16, 64'h5555, 1'b0);
    // long frame (24 bits): last 16 kept, R5
    mode_rise = 1'b0;
    run_frame(24, 64'h12_3456, 1'b0);
    // short frame: older bits remain above, R5
    run_frame(4, 64'hB, 1'b0);
    // idle edges ignored, then short frame shows register untouched (R3)
    idle_toggles(6);
    run_frame(4, 64'h6, 1'b0);
    // hold during frame, both modes (R8)
    run_frame(16, 64'h3C3C, 1'b1);
    mode_rise = 1'b1;
    run_frame(16, 64'hC00F, 1'b1);
    idle_toggles(3);

    // random frames
    for (int f = 0; f < 30; f++) begin
      logic [63:0] b;
      int n;
      b = {$urandom, $urandom};
      n = 8 + int'($urandom % 17);
      mode_rise = 1'($urandom);
      run_frame(n, b, ($urandom % 5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule